// File: doc/BRIEF.md
# PWM Fault Input Mode Controller

This block watches one active-low fault input that belongs to a PWM generator. It tells the output stage when the outputs must be replaced by their fault states. The raw pin first passes through a synchroniser and a deglitch filter. A three-state machine (normal, faulted, waiting for boundary) then decides when the override is raised and when it is dropped. Each fault also sets an interrupt flag, and software clears that flag with a one-cycle strobe. Software can also raise a fault with a manual strobe, and that strobe acts exactly like a fault seen on the pin.

Two recovery modes are available, chosen by one mode bit. In cycle-by-cycle mode the override follows the filtered input. In latched mode the override is only released once the input is high again and software has cleared the flag, in either order. In both modes the override drops only on a PWM cycle or half-cycle boundary pulse supplied from outside. The mode bit, the manual strobe, the flag-clear strobe and the boundary pulse are all sampled on the rising clock edge.

Top module: `flt_mode_ctrl`

## Requirements
- R1: After reset the override output and the interrupt flag are both 0.
- R2: A low level on the fault input that stays stable raises the override and sets the flag exactly SYNC_STAGES+FILT_CYCLES+1 clock edges after it is first present at an edge (6 edges with default parameters). This holds in both modes.
- R3: A low pulse on the fault input that lasts fewer than FILT_CYCLES clock cycles has no effect on the override or the flag. A pulse of exactly FILT_CYCLES cycles is accepted.
- R4: In cycle-by-cycle mode (mode bit 0) the override stays active while the filtered input is low. Once the input is high again, the override is released at a later boundary pulse, whatever the flag holds. The flag stays set until it is cleared.
- R5: In latched mode (mode bit 1) the override stays active until the filtered input is high and the flag has been cleared. Boundary pulses are ignored until both conditions are met, and the two conditions may arrive in either order.
- R6: The override falls only at a clock edge where the boundary input is 1. A boundary pulse in the same edge at which the release conditions first become true does not release the override; only a later pulse does.
- R7: A new fault, from the pin or the manual strobe, that arrives while the controller is waiting for a boundary keeps the override active and cancels the pending release, even if a boundary pulse arrives in the same cycle.
- R8: A manual-fault strobe raises the override and sets the flag at the next clock edge.
- R9: When a flag-clear strobe and a new fault event arrive in the same cycle, the flag stays set.
- R10: A flag-clear strobe with no fault event clears the flag at the next edge. Only this strobe clears the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fault_n_i | input | 1 | Raw fault pin, active low, asynchronous to clk |
| mode_latched_i | input | 1 | 1 = latched mode, 0 = cycle-by-cycle mode |
| manual_fault_i | input | 1 | Software strobe that forces a fault for one cycle |
| flag_clr_i | input | 1 | Software strobe that clears the interrupt flag |
| boundary_i | input | 1 | Pulse marking a PWM cycle or half-cycle boundary |
| override_o | output | 1 | 1 while the outputs must take their fault states |
| irq_flag_o | output | 1 | Interrupt flag, set on each fault event |

## Verification
The hardest state to reach is the waiting-for-boundary state in latched mode with the order of events reversed. The input must return high first, then boundary pulses must arrive and be ignored while the flag is still set. Only after that does the clear strobe come, with a boundary pulse placed on the same edge as the clear and on the edge right after it. The bench reaches this by timing every stimulus against the known pipeline delay of the filter. It also sweeps the delay between release and boundary, the glitch width across the filter threshold, and both modes.

// File: rtl/flt_mode_pkg.sv
package flt_mode_pkg;

  typedef enum logic [1:0] {
    ST_NORMAL   = 2'd0,
    ST_FAULTED  = 2'd1,
    ST_WAIT_BND = 2'd2
  } flt_state_e;

  // Release may be armed once the filtered input is inactive; latched mode
  // additionally needs the interrupt flag to be clear.
  function automatic logic release_ready(input logic latched,
                                         input logic fault_lvl,
                                         input logic flag);
    return !fault_lvl && (!latched || !flag);
  endfunction

  // Clock edges from a stable pin change to the registered reaction.
  function automatic int pin_latency(input int sync_stages, input int filt_cycles);
    return sync_stages + filt_cycles + 1;
  endfunction

endpackage

// File: rtl/flt_input_cond.sv
module flt_input_cond #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_CYCLES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n_i,
  output logic fault_lvl_o,
  output logic fault_fall_o
);
  localparam int CW = (FILT_CYCLES < 2) ? 1 : $clog2(FILT_CYCLES);

  logic [SYNC_STAGES-1:0] chain_q;
  logic                   samp;
  logic                   filt_q;
  logic                   filt_prev_q;
  logic [CW-1:0]          cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '1;
    else        chain_q <= {chain_q[SYNC_STAGES-2:0], pin_n_i};
  end

  assign samp = chain_q[SYNC_STAGES-1];

  // The filtered level flips only after FILT_CYCLES consecutive differing samples.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filt_q      <= 1'b1;
      filt_prev_q <= 1'b1;
      cnt_q       <= '0;
    end else begin
      filt_prev_q <= filt_q;
      if (samp == filt_q) begin
        cnt_q <= '0;
      end else if (cnt_q == CW'(FILT_CYCLES - 1)) begin
        filt_q <= samp;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end

  assign fault_lvl_o  = ~filt_q;
  assign fault_fall_o = filt_prev_q & ~filt_q;

  // R3: a sample that agrees with the filtered level never flips it
  a_r3_filter_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (samp == filt_q) |=> $stable(filt_q));

  // R3: the counter never runs past its threshold
  a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(FILT_CYCLES - 1));

endmodule

// File: rtl/flt_flag.sv
module flt_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flag_q <= 1'b0;
    else if (set_i) flag_q <= 1'b1;
    else if (clr_i) flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  // R9: a set event wins over a simultaneous clear
  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_o);

  // R10: a lone clear empties the flag
  a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !flag_o);

  // R10: the flag never drops without a clear strobe
  a_r10_only_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_o) |-> $past(clr_i));

endmodule

// File: rtl/flt_fsm.sv
module flt_fsm
  import flt_mode_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic latched_i,
  input  logic fault_lvl_i,
  input  logic manual_i,
  input  logic flag_i,
  input  logic boundary_i,
  output logic override_o
);
  flt_state_e state_q, state_d;
  logic       fault_now;
  logic       rel_ok;

  assign fault_now = fault_lvl_i | manual_i;
  assign rel_ok    = release_ready(latched_i, fault_lvl_i, flag_i) && !manual_i;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_NORMAL:   if (fault_now) state_d = ST_FAULTED;
      ST_FAULTED:  if (rel_ok)    state_d = ST_WAIT_BND;
      ST_WAIT_BND: begin
        if (fault_now)       state_d = ST_FAULTED;
        else if (!rel_ok)    state_d = ST_FAULTED;
        else if (boundary_i) state_d = ST_NORMAL;
      end
      default:               state_d = ST_FAULTED;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_NORMAL;
    else        state_q <= state_d;
  end

  assign override_o = (state_q != ST_NORMAL);

  // R2: any fault condition leaves the override active next cycle
  a_r2_fault_overrides: assert property (@(posedge clk) disable iff (!rst_n)
    fault_now |=> override_o);

  // R6: the override only falls on a boundary pulse
  a_r6_boundary_only: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(override_o) |-> $past(boundary_i));

  // R5: latched mode with the flag set cannot leave the faulted state
  a_r5_latched_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FAULTED && latched_i && flag_i) |=> (state_q == ST_FAULTED));

  // R7: a fault while waiting cancels the pending release
  a_r7_wait_refault: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT_BND && fault_now) |=> (state_q == ST_FAULTED));

  // R6: faulted never goes straight to normal
  a_r6_no_skip: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FAULTED) |=> (state_q != ST_NORMAL));

endmodule

// File: rtl/flt_mode_ctrl.sv
module flt_mode_ctrl #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_CYCLES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fault_n_i,
  input  logic mode_latched_i,
  input  logic manual_fault_i,
  input  logic flag_clr_i,
  input  logic boundary_i,
  output logic override_o,
  output logic irq_flag_o
);
  logic fault_lvl;
  logic fault_fall;
  logic set_evt;

  flt_input_cond #(
    .SYNC_STAGES(SYNC_STAGES),
    .FILT_CYCLES(FILT_CYCLES)
  ) u_cond (
    .clk         (clk),
    .rst_n       (rst_n),
    .pin_n_i     (fault_n_i),
    .fault_lvl_o (fault_lvl),
    .fault_fall_o(fault_fall)
  );

  assign set_evt = fault_fall | manual_fault_i;

  flt_flag u_flag (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (set_evt),
    .clr_i (flag_clr_i),
    .flag_o(irq_flag_o)
  );

  flt_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .latched_i  (mode_latched_i),
    .fault_lvl_i(fault_lvl),
    .manual_i   (manual_fault_i),
    .flag_i     (irq_flag_o),
    .boundary_i (boundary_i),
    .override_o (override_o)
  );

  // R8: a manual strobe both overrides and flags on the next edge
  a_r8_manual: assert property (@(posedge clk) disable iff (!rst_n)
    manual_fault_i |=> (override_o && irq_flag_o));

  // R2: a filtered falling edge sets the flag together with the override
  a_r2_fall_flags: assert property (@(posedge clk) disable iff (!rst_n)
    fault_fall |=> (irq_flag_o && override_o));

endmodule

// File: tb/test_flt_mode_ctrl.sv
`timescale 1ns/1ps
module test_flt_mode_ctrl;
  localparam int SYNC = 2;
  localparam int FILT = 3;
  localparam int LAT  = SYNC + FILT + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fault_n = 1'b1;
  logic mode_l = 1'b0;
  logic man = 1'b0;
  logic clr = 1'b0;
  logic bnd = 1'b0;
  logic ovr;
  logic flg;
  int   total = 0;
  int   bad = 0;

  always #4 clk = ~clk;

  flt_mode_ctrl #(.SYNC_STAGES(SYNC), .FILT_CYCLES(FILT)) i_flt_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .fault_n_i(fault_n), .mode_latched_i(mode_l),
    .manual_fault_i(man), .flag_clr_i(clr), .boundary_i(bnd),
    .override_o(ovr), .irq_flag_o(flg)
  );

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0b exp=%0b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset(input logic m);
    rst_n = 1'b0; fault_n = 1'b1; man = 1'b0; clr = 1'b0; bnd = 1'b0; mode_l = m;
    tick(3);
    rst_n = 1'b1;
    tick(1);
  endtask

  task automatic pulse_bnd();
    bnd = 1'b1; tick(1); bnd = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=running exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset(1'b0);
    chk("R1 override", ovr, 1'b0);
    chk("R1 flag", flg, 1'b0);

    // R2: entry latency in both modes
    for (int m = 0; m < 2; m++) begin
      do_reset(m[0]);
      fault_n = 1'b0;
      tick(LAT - 1);
      chk("R2 before latency", ovr, 1'b0);
      chk("R2 flag before", flg, 1'b0);
      tick(1);
      chk("R2 override at latency", ovr, 1'b1);
      chk("R2 flag at latency", flg, 1'b1);
    end

    // R3: glitch width sweep across the filter threshold
    for (int w = 1; w <= FILT; w++) begin
      do_reset(1'b0);
      fault_n = 1'b0; tick(w); fault_n = 1'b1;
      tick(LAT + 4);
      chk("R3 glitch override", ovr, (w >= FILT) ? 1'b1 : 1'b0);
      chk("R3 glitch flag", flg, (w >= FILT) ? 1'b1 : 1'b0);
    end

    // R4/R6: cycle-by-cycle release with swept boundary delay
    for (int d = 0; d < 4; d++) begin
      do_reset(1'b0);
      fault_n = 1'b0; tick(LAT + 3);
      pulse_bnd();
      chk("R4 held while low", ovr, 1'b1);
      fault_n = 1'b1; tick(LAT + d);
      chk("R6 waits for boundary", ovr, 1'b1);
      pulse_bnd();
      chk("R4 released at boundary", ovr, 1'b0);
      chk("R4 flag still set", flg, 1'b1);
    end

    // R5: latched, flag cleared while pin still low
    for (int d = 0; d < 3; d++) begin
      do_reset(1'b1);
      fault_n = 1'b0; tick(LAT);
      clr = 1'b1; tick(1); clr = 1'b0;
      chk("R10 flag cleared", flg, 1'b0);
      tick(4); pulse_bnd();
      chk("R5 held while pin low", ovr, 1'b1);
      fault_n = 1'b1; tick(LAT + d);
      chk("R5 waiting", ovr, 1'b1);
      pulse_bnd();
      chk("R5 released after both", ovr, 1'b0);
    end

    // R5/R6: latched, pin released first, flag cleared later
    do_reset(1'b1);
    fault_n = 1'b0; tick(LAT);
    fault_n = 1'b1; tick(LAT + 4);
    pulse_bnd();
    chk("R5 flag still set blocks release", ovr, 1'b1);
    clr = 1'b1; bnd = 1'b1; tick(1); clr = 1'b0;
    chk("R5 boundary with clear ignored", ovr, 1'b1);
    tick(1); bnd = 1'b0;
    chk("R6 boundary at arming edge ignored", ovr, 1'b1);
    tick(2);
    chk("R6 still waiting", ovr, 1'b1);
    pulse_bnd();
    chk("R5 released after clear", ovr, 1'b0);

    // R8: manual strobe
    do_reset(1'b0);
    man = 1'b1; tick(1); man = 1'b0;
    chk("R8 manual override", ovr, 1'b1);
    chk("R8 manual flag", flg, 1'b1);
    tick(1); pulse_bnd();
    chk("R8 manual released", ovr, 1'b0);

    // R7: refault while waiting, with a boundary in the same cycle
    do_reset(1'b0);
    man = 1'b1; tick(1); man = 1'b0;
    tick(1);
    man = 1'b1; bnd = 1'b1; tick(1); man = 1'b0; bnd = 1'b0;
    chk("R7 refault keeps override", ovr, 1'b1);
    tick(1); pulse_bnd();
    chk("R7 later boundary releases", ovr, 1'b0);

    // R9/R10: set versus clear
    do_reset(1'b0);
    clr = 1'b1; tick(1); clr = 1'b0;
    chk("R10 clear on empty flag", flg, 1'b0);
    man = 1'b1; clr = 1'b1; tick(1); man = 1'b0; clr = 1'b0;
    chk("R9 set wins over clear", flg, 1'b1);
    tick(5);
    chk("R10 flag holds without strobe", flg, 1'b1);
    clr = 1'b1; tick(1); clr = 1'b0;
    chk("R10 clear strobe", flg, 1'b0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule